// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address of every beat of one synchronous DRAM read or write burst. A controller pulses `start_i` with the first column, a length code and an ordering bit. From the next cycle the block presents one column per clock on `col_o`, with `valid_o` high. On the final beat of a fixed-length burst it raises `last_o`.

Bursts walk either sequentially, wrapping inside the aligned block of the burst length, or in interleaved order. A full-page burst is allowed in sequential order only. It wraps around the 512-column row and runs until it is stopped. A stop strobe ends a burst early. A new start on any cycle, including one where a burst is in progress, replaces the burst at once. A start with an illegal length setting is refused and reported on `err_o`. A write issued while the single-write option is on always gets a one-beat burst.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset `valid_o`, `last_o` and `err_o` are 0.
- R2: An accepted start in cycle t gives `valid_o`=1 and `col_o` equal to the start column in cycle t+1, and beat n follows in cycle t+1+n.
- R3: Length codes 1, 2 and 3 give bursts of 2, 4 and 8 beats. With `ilv_i`=0, beat n is at the start column's aligned block base plus ((start mod L)+n) mod L.
- R4: With `ilv_i`=1, beat n is the start column XOR n, for lengths 2, 4 and 8.
- R5: Length code 7 with `ilv_i`=0 is a full page. Beat n is (start+n) mod 512. It never raises `last_o` and it runs until it is stopped or restarted.
- R6: `last_o` is high exactly on the final beat of a fixed-length burst. `valid_o` is 0 in the cycle after that beat unless a new start was accepted.
- R7: A start is refused when it carries length code 4, 5 or 6, or code 7 together with `ilv_i`=1. A refused start raises `err_o` for the next cycle only and leaves any burst in progress unchanged.
- R8: `stop_i` without an accepted start ends the burst: `valid_o` is 0 in the next cycle.
- R9: An accepted start during a burst replaces it from the next cycle. This holds even when `stop_i` is high in the same cycle.
- R10: When `wr_i`=1 and `single_wr_i`=1, the burst is one beat long whatever the length code and ordering are, and it is never refused. Reads keep the programmed length.
- R11: Length code 0 gives a single beat with `last_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or restart a burst |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | Length: 0=1, 1=2, 2=4, 3=8, 7=full page |
| ilv_i | input | 1 | 1 = interleaved order |
| wr_i | input | 1 | The start is a write |
| single_wr_i | input | 1 | Writes are forced to one beat |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 9 | Current column |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | The previous cycle's start was refused |

## Verification
A start can coincide with a stop, with the last beat of a burst, or with a burst in progress. A refused start can also arrive during a running burst. The bench drives each of these on chosen cycles. It compares every output each clock against a behavioural model that applies start-over-stop priority. Restarts are also placed in the middle of a full-page wrap, so a stale count or a lost stop shows up as a wrong column or a wrong valid flag.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_d;
  logic             full_q, ilv_q, act_q, err_q;
  logic             full_d, bad_d, accept;

  always_comb begin
    mask_d = '0;
    full_d = 1'b0;
    bad_d  = 1'b0;
    case (len_code_i)
      3'd0:    mask_d = COL_W'(0);
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      3'd7:    begin mask_d = '1; full_d = 1'b1; bad_d = ilv_i; end
      default: bad_d = 1'b1;
    endcase
    if (wr_i && single_wr_i) begin
      mask_d = '0;
      full_d = 1'b0;
      bad_d  = 1'b0;
    end
  end

  assign accept = start_i & ~bad_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= start_i & bad_d;
      if (accept) begin
        base_q <= start_col_i;
        cnt_q  <= '0;
        mask_q <= mask_d;
        full_q <= full_d;
        ilv_q  <= ilv_i;
        act_q  <= 1'b1;
      end else if (stop_i) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        if (last_o) act_q <= 1'b0;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign col_o   = ilv_q ? (base_q ^ cnt_q)
                         : ((base_q & ~mask_q) | ((base_q + cnt_q) & mask_q));
  assign valid_o = act_q;
  assign last_o  = act_q & ~full_q & (cnt_q == mask_q);
  assign err_o   = err_q;
endmodule

module sdram_col_seq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             ilv_i,
  input logic             wr_i,
  input logic             single_wr_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o
);
  p_last_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);
  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !valid_o);
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> err_o || (valid_o && col_o == $past(start_col_i)));
  p_err_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i));
  p_keeps_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !start_i && !stop_i |=> valid_o);
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_col_seq_bench.sv
module sdram_col_seq_bench;
  logic       clk = 0, rst_n = 0;
  logic       start_i = 0, ilv_i = 0, wr_i = 0, single_wr_i = 0, stop_i = 0;
  logic [8:0] start_col_i = 0;
  logic [2:0] len_code_i = 0;
  logic [8:0] col_o;
  logic       valid_o, last_o, err_o;
  int tests = 0, fails = 0;
  bit done = 0;

  int m_act = 0, m_base = 0, m_n = 0, m_len = 1, m_ilv = 0, m_err = 0;

  always #2 clk = ~clk;

  sdram_col_seq u_sdram_col_seq (.*);

  function automatic int exp_col();
    int blk;
    if (m_len == 0) return (m_base + m_n) % 512;
    if (m_ilv != 0) return m_base ^ m_n;
    blk = m_base - (m_base % m_len);
    return blk + ((m_base % m_len) + m_n) % m_len;
  endfunction

  task automatic model_edge();
    int len;
    bit bad, forced;
    forced = wr_i && single_wr_i;
    bad = 0;
    case (len_code_i)
      0: len = 1;
      1: len = 2;
      2: len = 4;
      3: len = 8;
      7: begin len = 0; bad = ilv_i; end
      default: begin len = 1; bad = 1; end
    endcase
    if (forced) begin len = 1; bad = 0; end
    m_err = (start_i && bad) ? 1 : 0;
    if (start_i && !bad) begin
      m_act = 1; m_base = start_col_i; m_n = 0; m_len = len; m_ilv = ilv_i;
    end else if (stop_i) m_act = 0;
    else if (m_act != 0) begin
      if (m_len != 0 && m_n == m_len - 1) m_act = 0;
      else m_n = (m_n + 1) % 512;
    end
  endtask

  task automatic compare(string tag);
    int ev, ec, el;
    ev = m_act;
    ec = exp_col();
    el = (m_act != 0 && m_len != 0 && m_n == m_len - 1) ? 1 : 0;
    tests++;
    if (valid_o !== ev[0] || last_o !== el[0] || err_o !== m_err[0] ||
        (ev != 0 && col_o !== ec[8:0])) begin
      fails++;
      $display("FAIL %s: valid=%0d last=%0d err=%0d col=%0d expected valid=%0d last=%0d err=%0d col=%0d",
               tag, valid_o, last_o, err_o, col_o, ev, el, m_err, ec);
    end
  endtask

  task automatic step(string tag, bit st = 0, int col = 0, int code = 0,
                      bit il = 0, bit sp = 0, bit wr = 0);
    start_i = st; start_col_i = col[8:0]; len_code_i = code[2:0];
    ilv_i = il; stop_i = sp; wr_i = wr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int k);
    for (int i = 0; i < k; i++) step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tests++;
    if (valid_o !== 0 || last_o !== 0 || err_o !== 0) begin
      fails++;
      $display("FAIL R1: valid=%0d last=%0d err=%0d expected 0 0 0", valid_o, last_o, err_o);
    end
    idle("R1", 2);
    step("R11", 1, 5, 0);                 idle("R11", 3);
    step("R3", 1, 6, 2);                  idle("R3", 5);
    step("R3", 1, 9'h1FD, 3);             idle("R3", 9);
    step("R3", 1, 3, 1);                  idle("R3", 3);
    step("R4", 1, 5, 3, 1);               idle("R4", 9);
    step("R4", 1, 9'h1A6, 2, 1);          idle("R4", 5);
    step("R4", 1, 7, 1, 1);               idle("R4", 3);
    step("R5", 1, 510, 7);                idle("R5", 520);
    step("R8", 0, 0, 0, 0, 1);            idle("R8", 2);
    step("R8", 1, 40, 3);                 idle("R8", 2);
    step("R8", 0, 0, 0, 0, 1);            idle("R8", 3);
    step("R9", 1, 100, 3);                idle("R9", 2);
    step("R9", 1, 200, 2, 1);             idle("R9", 1);
    step("R9", 1, 300, 1, 0, 1);          idle("R9", 3);
    step("R9", 1, 16, 1);                 step("R9");
    step("R9", 1, 33, 0);                 idle("R9", 2);
    step("R9", 1, 250, 7);                idle("R9", 5);
    step("R9", 1, 8, 2, 1);               idle("R6", 5);
    step("R7", 1, 12, 7, 1);              idle("R7", 2);
    step("R7", 1, 20, 3);                 step("R7");
    step("R7", 1, 50, 5);                 idle("R7", 1);
    step("R7", 1, 60, 7, 1);              idle("R7", 8);
    step("R7", 1, 70, 4);                 step("R7", 1, 71, 6);
    idle("R7", 2);
    single_wr_i = 1;
    step("R10", 1, 77, 3, 0, 0, 1);       idle("R10", 2);
    step("R10", 1, 90, 7, 1, 0, 1);       idle("R10", 2);
    step("R10", 1, 4, 2, 0, 0, 0);        idle("R10", 5);
    single_wr_i = 0;
    step("R10", 1, 4, 2, 0, 0, 1);        idle("R10", 5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule